// File: doc/BRIEF.md
# Peak-Hold Decimating Echo Acquisition Controller

This block runs the capture of one ultrasonic echo line from a 16-bit pipelined converter. The converter presents one word on every clock. A host first places a group size, a probe lead-in delay and a line length into holding registers with a load strobe. It then pulses start. The block waits out the programmed delay plus the converter's fixed pipeline latency. After that it takes one sample per clock. Each sample is converted to two's complement when the converter is set to straight offset binary.

Accepted samples are collected in groups of the programmed size. From each group only the signed maximum is kept, and that value is emitted as a single word with a one-cycle valid strobe. This shortens the record but keeps the echo envelope. The block counts emitted words. Once the line length is reached it stops and raises a done flag. A start pulse during a capture abandons the current capture and begins again from the delay phase.

The output has no back-pressure. The consumer must take every word in the cycle its valid strobe is high. At most one word appears per group, so the output rate is the clock rate divided by the group size. The sample input has no valid or ready pins either, because the converter delivers a word on every clock.

Top module: `acq_peak_decim`

## Requirements
- R1: Group size, delay, line length and input format are captured from the configuration inputs only on a clock where `cfg_load` is high. A change on those inputs without `cfg_load` has no effect on the output.
- R2: When `start` is sampled high at clock edge E, the first sample accepted is the one present at edge E+D+13, where D is the held delay. The 12 cycles of converter latency and the delay cycles are discarded.
- R3: With `cfg_twos` held at 0, the input is straight offset binary and is converted by inverting bit 15. With `cfg_twos` held at 1, the input is used unchanged. Output words are always two's complement.
- R4: Each group of N accepted samples yields one output word equal to the largest sample in the group under signed comparison. The first sample of a group initialises the running maximum, and a later sample replaces it only if it is strictly greater.
- R5: A held group size of 0 behaves as 1. With a group size of 1, every accepted sample appears unchanged at the output.
- R6: `out_valid` is high for exactly one cycle per group. It rises in the cycle after the edge that accepted the group's last sample. `out_count` increases by one in that same cycle and holds its value at all other times outside a restart.
- R7: After L output words, where L is the held line length and 0 counts as 1, `done` rises, `busy` falls and no further words are emitted. `done` stays high until the next start.
- R8: A start pulse during a capture discards any partial group, clears `out_count` and `done`, and restarts the delay phase. No output word is emitted in the cycle after the start.
- R9: After reset the block is idle, with `busy`, `done`, `out_valid` and `out_count` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures the configuration inputs into the holding registers |
| cfg_ratio | input | 16 | Group size in input samples |
| cfg_delay | input | 16 | Probe lead-in delay in clocks |
| cfg_line_len | input | 16 | Output words per line |
| cfg_twos | input | 1 | 1: input is two's complement; 0: straight offset binary |
| start | input | 1 | Begins or restarts a capture |
| adc_data | input | 16 | Converter sample, one per clock |
| out_valid | output | 1 | One-cycle strobe for a compressed word |
| out_data | output | 16 | Group maximum, two's complement |
| out_count | output | 16 | Words emitted in the current line |
| busy | output | 1 | Delay or sampling phase is active |
| done | output | 1 | Line complete |

## Verification
If the delay or latency counter is off by even one cycle, the group boundaries move by that cycle. The first output word then differs from the reference at its very first strobe, which is D+12+N cycles after start. A corrupted running maximum, or one that carries over between groups, shows on the very next strobe as a wrong `out_data`. A group counter that slips shows as a strobe one cycle early or late, and `out_count` moves with it. A fault in the line-length logic shows up as `done` rising at the wrong strobe, or as strobes that continue after `done`.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_DONE   = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_fmt.sv
module acq_fmt #(
  parameter int W = 16
) (
  input  logic [W-1:0]        raw,
  input  logic                twos,
  output logic signed [W-1:0] smp
);
  // Offset binary becomes two's complement by flipping the sign bit.
  always_comb begin
    if (twos) smp = raw;
    else      smp = {~raw[W-1], raw[W-2:0]};
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int CW  = 16,
  parameter int LAT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] delay,
  input  logic [CW-1:0] line_len,
  input  logic          grp_last,
  output logic          sample_en,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] count
);
  localparam int TW = CW + 1;

  acq_state_e    state;
  logic [TW-1:0] wcnt;
  logic [TW-1:0] total;
  logic [CW-1:0] len_eff;
  logic [CW-1:0] cnt_nx;

  assign total   = {1'b0, delay} + TW'(LAT);
  assign len_eff = (line_len == '0) ? CW'(1) : line_len;
  assign cnt_nx  = count + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
      count <= '0;
    end else if (start) begin
      count <= '0;
      wcnt  <= total;
      state <= (total == '0) ? ST_SAMPLE : ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: begin
          wcnt <= wcnt - TW'(1);
          if (wcnt == TW'(1)) state <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (grp_last) begin
            count <= cnt_nx;
            if (cnt_nx == len_eff) state <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sample_en = (state == ST_SAMPLE);
  assign busy      = (state == ST_WAIT) || (state == ST_SAMPLE);
  assign done      = (state == ST_DONE);
endmodule

// File: rtl/acq_peak.sv
module acq_peak #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                en,
  input  logic signed [W-1:0] smp,
  input  logic [CW-1:0]       ratio,
  output logic                grp_last,
  output logic                out_valid,
  output logic [W-1:0]        out_data
);
  logic signed [W-1:0] hold;
  logic signed [W-1:0] cand;
  logic [CW-1:0]       gcnt;
  logic [CW-1:0]       rem;
  logic [CW-1:0]       ratio_eff;
  logic                first;

  assign ratio_eff = (ratio == '0) ? CW'(1) : ratio;
  assign first     = (gcnt == '0);
  assign rem       = first ? ratio_eff : gcnt;
  assign cand      = (first || (smp > hold)) ? smp : hold;
  assign grp_last  = en && !clear && (rem == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt      <= '0;
      hold      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (clear) begin
        gcnt <= '0;
      end else if (en) begin
        if (grp_last) begin
          out_valid <= 1'b1;
          out_data  <= cand;
          gcnt      <= '0;
        end else begin
          gcnt <= rem - CW'(1);
          hold <= cand;
        end
      end
    end
  end
endmodule

// File: rtl/acq_peak_decim.sv
module acq_peak_decim #(
  parameter int W   = 16,
  parameter int CW  = 16,
  parameter int LAT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_ratio,
  input  logic [CW-1:0] cfg_delay,
  input  logic [CW-1:0] cfg_line_len,
  input  logic          cfg_twos,
  input  logic          start,
  input  logic [W-1:0]  adc_data,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] out_count,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0]       h_ratio, h_delay, h_len;
  logic                h_twos;
  logic signed [W-1:0] smp;
  logic                sample_en, grp_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_ratio <= CW'(1);
      h_delay <= '0;
      h_len   <= CW'(1);
      h_twos  <= 1'b1;
    end else if (cfg_load) begin
      h_ratio <= cfg_ratio;
      h_delay <= cfg_delay;
      h_len   <= cfg_line_len;
      h_twos  <= cfg_twos;
    end
  end

  acq_fmt #(.W(W)) u_fmt (
    .raw (adc_data),
    .twos(h_twos),
    .smp (smp)
  );

  acq_seq #(.CW(CW), .LAT(LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .delay    (h_delay),
    .line_len (h_len),
    .grp_last (grp_last),
    .sample_en(sample_en),
    .busy     (busy),
    .done     (done),
    .count    (out_count)
  );

  acq_peak #(.W(W), .CW(CW)) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .en       (sample_en),
    .smp      (smp),
    .ratio    (h_ratio),
    .grp_last (grp_last),
    .out_valid(out_valid),
    .out_data (out_data)
  );
endmodule

// File: rtl/acq_peak_decim_chk.sv
module acq_peak_decim_chk #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_valid,
  input logic [CW-1:0] out_count,
  input logic          busy,
  input logic          done
);
  p_valid_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count == $past(out_count) + CW'(1)));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(start)) |-> $stable(out_count));

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (!out_valid && out_count == '0));
endmodule

bind acq_peak_decim acq_peak_decim_chk #(.W(W), .CW(CW)) u_chk (.*);

// File: tb/acq_peak_decim_tb.sv
module acq_peak_decim_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_ratio = 16'd1, cfg_delay = 16'd0, cfg_line_len = 16'd1;
  logic        cfg_twos = 1'b1;
  logic        start = 1'b0;
  logic [15:0] adc_data = 16'd0;
  logic        out_valid, busy, done;
  logic [15:0] out_data, out_count;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string cur_req = "R9";
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_peak_decim u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ratio(cfg_ratio),
    .cfg_delay(cfg_delay), .cfg_line_len(cfg_line_len), .cfg_twos(cfg_twos),
    .start(start), .adc_data(adc_data), .out_valid(out_valid),
    .out_data(out_data), .out_count(out_count), .busy(busy), .done(done)
  );

  // Behavioural reference: 0 idle, 1 waiting, 2 sampling, 3 finished
  int          m_phase = 0;
  int          m_wait_left = 0;
  int          m_ratio = 1, m_delay = 0, m_len = 1;
  bit          m_twos = 1'b1;
  shortint     m_group[$];
  logic        m_valid = 1'b0;
  logic [15:0] m_data = 16'd0;
  logic [15:0] m_count = 16'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_valid = 1'b0; m_count = 16'd0; m_group.delete();
      m_ratio = 1; m_delay = 0; m_len = 1; m_twos = 1'b1;
    end else begin
      m_valid = 1'b0;
      if (start) begin
        m_group.delete();
        m_count = 16'd0;
        m_wait_left = m_delay + LATENCY;
        m_phase = (m_wait_left == 0) ? 2 : 1;
      end else if (m_phase == 1) begin
        m_wait_left--;
        if (m_wait_left == 0) m_phase = 2;
      end else if (m_phase == 2) begin
        shortint s;
        s = m_twos ? shortint'(adc_data) : shortint'(adc_data ^ 16'h8000);
        m_group.push_back(s);
        if (m_group.size() == ((m_ratio == 0) ? 1 : m_ratio)) begin
          shortint best;
          best = m_group[0];
          foreach (m_group[i]) if (m_group[i] > best) best = m_group[i];
          m_valid = 1'b1;
          m_data = 16'(best);
          m_group.delete();
          m_count = m_count + 16'd1;
          if (int'(m_count) == ((m_len == 0) ? 1 : m_len)) m_phase = 3;
        end
      end
      if (cfg_load) begin
        m_ratio = int'(cfg_ratio); m_delay = int'(cfg_delay);
        m_len = int'(cfg_line_len); m_twos = cfg_twos;
      end
    end
  end

  task automatic check(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    check("out_valid", {15'd0, out_valid}, {15'd0, m_valid});
    if (m_valid) check("out_data", out_data, m_data);
    check("out_count", out_count, m_count);
    check("busy", {15'd0, busy}, {15'd0, (m_phase == 1 || m_phase == 2)});
    check("done", {15'd0, done}, {15'd0, (m_phase == 3)});
  end

  task automatic step(int mode);
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: adc_data = lfsr;
      1: adc_data = 16'(cycles * 37);
      default: adc_data = 16'(16'h7FF0 + cycles[3:0]);
    endcase
  endtask

  task automatic configure(int r, int d, int l, bit tw);
    @(negedge clk);
    cfg_ratio = 16'(r); cfg_delay = 16'(d); cfg_line_len = 16'(l); cfg_twos = tw;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(int mode, int maxc);
    for (int i = 0; i < maxc; i++) begin
      step(mode);
      if (done) break;
    end
    repeat (3) step(mode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R9";
    repeat (3) step(0);

    cur_req = "R2 R4 R6";
    configure(4, 5, 6, 1'b1);
    kick();
    run(0, 200);

    cur_req = "R2 R3";
    configure(3, 0, 8, 1'b0);
    kick();
    run(1, 200);

    cur_req = "R3 R4";
    configure(5, 2, 4, 1'b0);
    kick();
    run(2, 200);

    cur_req = "R5";
    configure(0, 3, 5, 1'b1);
    kick();
    run(0, 200);
    configure(1, 1, 7, 1'b1);
    kick();
    run(1, 200);

    cur_req = "R1";
    configure(2, 4, 5, 1'b1);
    @(negedge clk);
    cfg_ratio = 16'd7; cfg_delay = 16'd1; cfg_line_len = 16'd2; cfg_twos = 1'b0;
    kick();
    run(0, 200);

    cur_req = "R8";
    configure(3, 2, 10, 1'b1);
    kick();
    for (int i = 0; i < 22; i++) step(0);
    kick();
    for (int i = 0; i < 5; i++) step(0);
    kick();
    run(0, 200);

    cur_req = "R7";
    configure(2, 0, 0, 1'b1);
    kick();
    run(0, 100);
    for (int i = 0; i < 10; i++) step(0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule